// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register Block

This block holds the registers a host uses to run one bus-master disk DMA channel. Software programs a 32-bit descriptor table pointer, chooses the transfer direction, then sets the start bit. The block turns those writes into a run request, a direction and a table base for a separate transfer engine. It then gathers what comes back from the engine and the drive into one status byte.

The status byte has three kinds of bits. The busy bit follows the channel's live state. The error and interrupt bits are sticky event flags that software clears by writing 1 to them. Two plain read/write bits record whether drive 0 and drive 1 may use DMA. The interrupt output follows the sticky interrupt flag. A run has ended cleanly when status bits 2:0 read 100b: interrupt seen, no error, no longer busy.

The register bus is a single-cycle, byte-enabled, 32-bit port. A write completes on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. The block moves no data streams, so it has no valid/ready handshake.

Top module: `dcr_chan_regs`

## Requirements
- R1: After reset every register reads zero, and `eng_run`, `eng_to_mem`, `eng_base` and `irq_out` are low.
- R2: The command byte sits at byte lane 0 of address 0. Writing its bit 0 as 1 while that bit holds 0 raises `eng_run` and status bit 0 from the next clock.
- R3: Writing command bit 0 as 0 drops `eng_run` and status bit 0 from the next clock.
- R4: An `eng_done` pulse while running drops `eng_run` and status bit 0, and command bit 0 keeps its written value. Writing 1 to an already-set start bit does not restart the channel; it must be written 0 first.
- R5: Command bit 3 selects the direction, where 1 means the device writes to memory, and drives `eng_to_mem`. A write to bit 3 is ignored while the channel is running.
- R6: An `eng_err` pulse sets status bit 1 (lane 2, data bit 17). Writing 1 to that bit clears it and writing 0 leaves it unchanged. If a set and a clear land in the same cycle, the set wins.
- R7: A high `dev_irq` sets status bit 2 (data bit 18), which clears by writing 1 to it, with the set winning. `irq_out` equals status bit 2.
- R8: Status bits 5 and 6 (data bits 21 and 22) are plain read/write drive capability flags. Status bits 3, 4 and 7 always read 0.
- R9: The table pointer is at address 4, written lane by lane under `bus_be`. Its low two bits always read 0, and its value drives `eng_base`.
- R10: A write updates the command byte only when `bus_be[0]` is set and the status byte only when `bus_be[2]` is set. Addresses other than 0 and 4 read zero and ignore writes.
- R11: A run that finishes through `eng_done` and then gets a device interrupt leaves status bits 2:0 reading exactly 100b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte address of the register word (0 or 4) |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| eng_run | output | 1 | Run request to the transfer engine |
| eng_to_mem | output | 1 | Direction: 1 when the device writes to memory |
| eng_base | output | 32 | Descriptor table base address |
| eng_done | input | 1 | Engine finished its last descriptor (pulse) |
| eng_err | input | 1 | Engine hit a transfer error (pulse) |
| dev_irq | input | 1 | Interrupt request from the drive |
| irq_out | output | 1 | Channel interrupt to the host |

## Verification
The assertions assume that `eng_done` and `eng_err` are clean single-cycle pulses and that every input is at a known level once reset is released. They also assume the engine reports completion only for a run it was given. The bench meets these assumptions by driving every input on the falling edge and holding each event high for exactly one cycle. It checks busy, direction and sticky flags only through the read port and the engine-facing outputs, half a cycle after the edge that updates them. Same-cycle set and clear cases are driven on purpose so the priority rule is exercised.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int LANE_CMD = 0;
  localparam int LANE_ST  = 2;
  localparam int CMD_GO   = 0;
  localparam int CMD_DIR  = 3;
  localparam int ST_BUSY  = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_IRQ   = 2;
  localparam int ST_CAP0  = 5;
  localparam int ST_CAP1  = 6;

  typedef struct packed {
    logic cap1;
    logic cap0;
    logic irq;
    logic err;
    logic busy;
  } chan_status_t;
endpackage

// File: rtl/dcr_cmd.sv
module dcr_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cmd,
  input  logic w_go,
  input  logic w_dir,
  input  logic eng_done,
  output logic go_q,
  output logic dir_q,
  output logic busy_q
);
  logic start_edge;
  assign start_edge = wr_cmd && w_go && !go_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        go_q <= w_go;
        if (!busy_q) dir_q <= w_dir;
      end
      if (start_edge)
        busy_q <= 1'b1;
      else if (wr_cmd && !w_go)
        busy_q <= 1'b0;
      else if (eng_done && busy_q)
        busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dcr_status.sv
module dcr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_st,
  input  logic w_err,
  input  logic w_irq,
  input  logic w_cap0,
  input  logic w_cap1,
  input  logic set_err,
  input  logic set_irq,
  output logic err_q,
  output logic irq_q,
  output logic cap0_q,
  output logic cap1_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      cap0_q <= 1'b0;
      cap1_q <= 1'b0;
    end else begin
      if (set_err)             err_q <= 1'b1;
      else if (wr_st && w_err) err_q <= 1'b0;
      if (set_irq)             irq_q <= 1'b1;
      else if (wr_st && w_irq) irq_q <= 1'b0;
      if (wr_st) begin
        cap0_q <= w_cap0;
        cap1_q <= w_cap1;
      end
    end
  end
endmodule

// File: rtl/dcr_tptr.sv
module dcr_tptr #(
  parameter int ALIGN_BITS = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_ptr,
  input  logic [dcr_pkg::LANES-1:0]         be,
  input  logic [dcr_pkg::DATA_W-1:0]        wdata,
  output logic [dcr_pkg::DATA_W-1:0]        ptr_q
);
  localparam int W = dcr_pkg::DATA_W;
  localparam logic [W-1:0] KEEP_MASK = ~((W'(1) << ALIGN_BITS) - W'(1));

  logic [W-1:0] merged;

  for (genvar g = 0; g < dcr_pkg::LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : ptr_q[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (wr_ptr) ptr_q <= merged & KEEP_MASK;
  end
endmodule

// File: rtl/dcr_chan_regs.sv
module dcr_chan_regs #(
  parameter int ADDR_W     = 3,
  parameter int ALIGN_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [dcr_pkg::LANES-1:0]  bus_be,
  input  logic [dcr_pkg::DATA_W-1:0] bus_wdata,
  output logic [dcr_pkg::DATA_W-1:0] bus_rdata,
  output logic                       eng_run,
  output logic                       eng_to_mem,
  output logic [dcr_pkg::DATA_W-1:0] eng_base,
  input  logic                       eng_done,
  input  logic                       eng_err,
  input  logic                       dev_irq,
  output logic                       irq_out
);
  import dcr_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(4);
  localparam int CMD_LO = LANE_CMD * 8;
  localparam int ST_LO  = LANE_ST * 8;

  logic sel_ctrl, sel_ptr;
  logic wr_cmd, wr_st, wr_ptr;
  logic go_q, dir_q, busy_q;
  logic st_err, st_irq, cap0_q, cap1_q;
  logic [DATA_W-1:0] ptr_q;
  chan_status_t st;
  logic [7:0] cmd_byte, st_byte;

  assign sel_ctrl = (bus_addr == A_CTRL);
  assign sel_ptr  = (bus_addr == A_PTR);
  assign wr_cmd   = bus_we && sel_ctrl && bus_be[LANE_CMD];
  assign wr_st    = bus_we && sel_ctrl && bus_be[LANE_ST];
  assign wr_ptr   = bus_we && sel_ptr;

  dcr_cmd u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cmd   (wr_cmd),
    .w_go     (bus_wdata[CMD_LO + CMD_GO]),
    .w_dir    (bus_wdata[CMD_LO + CMD_DIR]),
    .eng_done (eng_done),
    .go_q     (go_q),
    .dir_q    (dir_q),
    .busy_q   (busy_q)
  );

  dcr_status u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_st   (wr_st),
    .w_err   (bus_wdata[ST_LO + ST_ERR]),
    .w_irq   (bus_wdata[ST_LO + ST_IRQ]),
    .w_cap0  (bus_wdata[ST_LO + ST_CAP0]),
    .w_cap1  (bus_wdata[ST_LO + ST_CAP1]),
    .set_err (eng_err),
    .set_irq (dev_irq),
    .err_q   (st_err),
    .irq_q   (st_irq),
    .cap0_q  (cap0_q),
    .cap1_q  (cap1_q)
  );

  dcr_tptr #(.ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ptr(wr_ptr),
    .be    (bus_be),
    .wdata (bus_wdata),
    .ptr_q (ptr_q)
  );

  always_comb begin
    st.busy  = busy_q;
    st.err   = st_err;
    st.irq   = st_irq;
    st.cap0  = cap0_q;
    st.cap1  = cap1_q;
    cmd_byte = '0;
    cmd_byte[CMD_GO]  = go_q;
    cmd_byte[CMD_DIR] = dir_q;
    st_byte  = '0;
    st_byte[ST_BUSY] = st.busy;
    st_byte[ST_ERR]  = st.err;
    st_byte[ST_IRQ]  = st.irq;
    st_byte[ST_CAP0] = st.cap0;
    st_byte[ST_CAP1] = st.cap1;
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[CMD_LO +: 8] = cmd_byte;
      bus_rdata[ST_LO  +: 8] = st_byte;
    end else if (sel_ptr) begin
      bus_rdata = ptr_q;
    end
  end

  assign eng_run    = busy_q;
  assign eng_to_mem = dir_q;
  assign eng_base   = ptr_q;
  assign irq_out    = st_irq;
endmodule

// File: rtl/dcr_chan_regs_chk.sv
module dcr_chan_regs_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              eng_run,
  input logic              eng_to_mem,
  input logic              eng_done,
  input logic              eng_err,
  input logic              dev_irq,
  input logic              irq_out,
  input logic              err_flag
);
  // R7: a device interrupt is latched by the next edge
  p_irq_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq |=> irq_out);

  // R7: the output pin agrees with status bit 2 as read back
  p_irq_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (irq_out == bus_rdata[18]));

  // R6: an engine error is latched by the next edge
  p_err_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> err_flag);

  // R4: completion ends the run
  p_done_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_run) |=> !eng_run);

  // R5: direction cannot move while running
  p_dir_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_run |=> $stable(eng_to_mem));

  // R2: a run only begins after a register write
  p_start_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_run) |-> $past(bus_we));
endmodule

bind dcr_chan_regs dcr_chan_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .eng_run    (eng_run),
  .eng_to_mem (eng_to_mem),
  .eng_done   (eng_done),
  .eng_err    (eng_err),
  .dev_irq    (dev_irq),
  .irq_out    (irq_out),
  .err_flag   (st_err)
);

// File: tb/dcr_chan_regs_test.sv
module dcr_chan_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_run, eng_to_mem, irq_out;
  logic [31:0] eng_base;
  logic        eng_done = 1'b0, eng_err = 1'b0, dev_irq = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcr_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_run(eng_run), .eng_to_mem(eng_to_mem), .eng_base(eng_base),
    .eng_done(eng_done), .eng_err(eng_err), .dev_irq(dev_irq),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write cycle; returns on the following falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_done();
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic pulse_err();
    eng_err = 1'b1; @(negedge clk); eng_err = 1'b0;
  endtask

  task automatic pulse_irq();
    dev_irq = 1'b1; @(negedge clk); dev_irq = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 ctrl word", d, 32'h0);
    rd(3'd4, d); check("R1 pointer", d, 32'h0);
    check("R1 outputs", {28'h0, eng_run, eng_to_mem, irq_out, |eng_base}, 32'h0);
  endtask

  task automatic t_pointer();
    logic [31:0] d;
    wr(3'd4, 32'hDEADBEEF, 4'hF);
    rd(3'd4, d); check("R9 aligned readback", d, 32'hDEADBEEC);
    check("R9 eng_base", eng_base, 32'hDEADBEEC);
    wr(3'd4, 32'h00000013, 4'h1);
    rd(3'd4, d); check("R9 single lane", d, 32'hDEADBE10);
    wr(3'd2, 32'hFFFFFFFF, 4'hF);
    rd(3'd2, d); check("R10 unmapped reads zero", d, 32'h0);
    rd(3'd4, d); check("R10 unmapped write ignored", d, 32'hDEADBE10);
  endtask

  task automatic t_start_dir();
    logic [31:0] d;
    wr(3'd0, 32'h09, 4'h1);
    check("R2 run raised", {30'h0, eng_run, eng_to_mem}, 32'h3);
    rd(3'd0, d); check("R2 busy and cmd", d, 32'h00010009);
    wr(3'd0, 32'h01, 4'h1);
    check("R5 dir held while running", eng_to_mem, 32'h1);
    wr(3'd0, 32'h00, 4'h1);
    check("R3 stop", eng_run, 32'h0);
    rd(3'd0, d); check("R3 status busy clear", d, 32'h00000008);
    wr(3'd0, 32'h00, 4'h1);
    check("R5 dir accepted when idle", eng_to_mem, 32'h0);
    wr(3'd0, 32'h01, 4'h2);
    check("R10 cmd lane disabled", eng_run, 32'h0);
  endtask

  task automatic t_done();
    logic [31:0] d;
    wr(3'd0, 32'h01, 4'h1);
    check("R4 running", eng_run, 32'h1);
    pulse_done();
    check("R4 done stops", eng_run, 32'h0);
    rd(3'd0, d); check("R4 start bit kept", d, 32'h00000001);
    wr(3'd0, 32'h01, 4'h1);
    check("R4 no restart on repeat", eng_run, 32'h0);
    wr(3'd0, 32'h00, 4'h1);
    wr(3'd0, 32'h01, 4'h1);
    check("R4 restart after clear", eng_run, 32'h1);
    wr(3'd0, 32'h00, 4'h1);
  endtask

  task automatic t_err();
    logic [31:0] d;
    pulse_err();
    rd(3'd0, d); check("R6 error set", d, 32'h00020000);
    wr(3'd0, 32'h00000000, 4'h4);
    rd(3'd0, d); check("R6 write 0 keeps", d, 32'h00020000);
    wr(3'd0, 32'h00020000, 4'h1);
    rd(3'd0, d); check("R10 status lane disabled", d, 32'h00020000);
    eng_err = 1'b1;
    wr(3'd0, 32'h00020000, 4'h4);
    eng_err = 1'b0;
    rd(3'd0, d); check("R6 set wins", d, 32'h00020000);
    wr(3'd0, 32'h00020000, 4'h4);
    rd(3'd0, d); check("R6 write 1 clears", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulse_irq();
    check("R7 irq_out set", irq_out, 32'h1);
    rd(3'd0, d); check("R7 status bit 2", d, 32'h00040000);
    wr(3'd0, 32'h00000000, 4'h4);
    check("R7 write 0 keeps", irq_out, 32'h1);
    dev_irq = 1'b1;
    wr(3'd0, 32'h00040000, 4'h4);
    dev_irq = 1'b0;
    check("R7 set wins", irq_out, 32'h1);
    wr(3'd0, 32'h00040000, 4'h4);
    check("R7 write 1 clears", irq_out, 32'h0);
  endtask

  task automatic t_caps();
    logic [31:0] d;
    wr(3'd0, 32'h00F90000, 4'h4);
    rd(3'd0, d); check("R8 caps and reserved", d, 32'h00600000);
    wr(3'd0, 32'h00200000, 4'h4);
    rd(3'd0, d); check("R8 cap0 only", d, 32'h00200000);
  endtask

  task automatic t_success();
    logic [31:0] d;
    wr(3'd0, 32'h09, 4'h1);
    pulse_done();
    pulse_irq();
    rd(3'd0, d); check("R11 status 2:0 is 100b", {29'h0, d[18:16]}, 32'h4);
    check("R11 irq_out", irq_out, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_start_dir();
    t_done();
    t_err();
    t_irq();
    t_caps();
    t_success();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule